// File: doc/BRIEF.md
# Autonomous Touch Measurement Sequencer

This block runs the self-timed measurement mode of a resistive touch-panel controller. A host command byte launches a programmed scan over a list of measurement channels (panel axes, pressure planes, two temperature references or the auxiliary input). For every channel in the list it first lets the panel settle for a programmable interval, then performs a fixed number of tracking-plus-conversion steps through an abstract converter port. It reduces each channel's samples to one value by dropping the smallest and largest sample and averaging the rest.

While a scan runs, the pen-interrupt output is held low and doubles as a "busy" flag. Its rising edge tells the host that results are ready. The internal oscillator enable stays on for a short hold window after the scan, and pen detection resumes when that window ends. The host fetches the results with a read command followed by pop strobes, in scan order. The readout is destructive: popping past the stored results yields zeros, and the store empties once its last result has been popped. The panel drivers and the oscillator are represented only by enable outputs.

Top module: `tsc_seq_ctrl`

## Requirements
- R1: A command byte 0xAE while idle starts a scan whose channel list comes from `seq_mode`. Modes: 0 gives X,Y,Z1,Z2; 1 gives X,Y; 2 gives X; 3 gives Y; 4 gives Z1,Z2; 5 gives T0,T1; 6 gives AUX. `adc_chan` codes are X=0, Y=1, Z1=2, Z2=3, T0=4, T1=5, AUX=6.
- R2: Before each channel the block waits `ival_code`-selected microseconds times CLK_PER_US cycles, with status 01. Codes 0..7 select 0, 5, 10, 20, 50, 100, 200 and 500 us. A zero wait skips the wait state.
- R3: Each channel takes N_CONV steps of STEP_CYC (20) cycles with `adc_trk` high and status 10. `adc_smp` pulses once, in the last cycle of each step, when `adc_data` is taken.
- R4: Each stored result is (sum of the N_CONV samples − minimum − maximum) / (N_CONV − 2), truncated.
- R5: `status` reads 00 when idle with no stored results, 01 while waiting, 10 while converting, and 11 when idle with results stored.
- R6: `pen_irq_n` is low for the whole scan and high for HOLD_CYC = ceil(2.8·CLK_PER_US) cycles after it. After that window it equals the inverse of `pen_touch`.
- R7: Command 0xAF rewinds the read pointer. Each `rd_pop` puts the next result on `rd_data` one cycle later, in scan order. Pops past the last result give 0, and the store is emptied once its last result is popped.
- R8: A 0xAE command during a scan is ignored. The running scan keeps its channel list and length.
- R9: Mode 7 finishes at once: status is 00 on the next cycle, no result is stored, and earlier results are discarded.
- R10: `osc_en` is high during a scan and during the hold window, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Decoded host command byte |
| seq_mode | input | 3 | Channel list selection |
| ival_code | input | 3 | Settling interval code |
| rd_pop | input | 1 | Result pop strobe |
| rd_data | output | DW | Popped result |
| adc_data | input | DW | Converter result |
| adc_trk | output | 1 | Tracking/conversion step active |
| adc_smp | output | 1 | Converter result capture strobe |
| adc_chan | output | 3 | Channel being measured |
| drv_en | output | 1 | Panel driver enable for position and pressure channels |
| osc_en | output | 1 | Oscillator enable |
| pen_touch | input | 1 | Raw pen contact detect |
| pen_irq_n | output | 1 | Pen interrupt / scan-done flag, active low |
| status | output | 2 | Sequencer status code |

## Verification
The checker confirms these relations on every cycle: every capture strobe falls inside a conversion step, tracking is off during the settling wait, the interrupt is low and the oscillator is on while busy, the hold window follows a scan end, a reserved start leaves the block idle and empty, a start during a scan keeps it busy, and an empty store pops zeros. Only the bench scenarios can show the scan order of the channels, the exact wait and conversion cycle counts for each interval code, the trimmed-mean values (including an all-full-scale input), the length of the hold window, and a destructive readout that is split across several pop bursts.

// File: rtl/tsc_seq_pkg.sv
package tsc_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} seq_state_e;

  localparam logic [7:0] CMD_START = 8'hAE;
  localparam logic [7:0] CMD_READ  = 8'hAF;

  // number of channels in a scan list (0 for the reserved code)
  function automatic logic [2:0] seq_len(input logic [2:0] mode);
    case (mode)
      3'd0:    return 3'd4;
      3'd1:    return 3'd2;
      3'd4:    return 3'd2;
      3'd5:    return 3'd2;
      3'd2,
      3'd3,
      3'd6:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // channel code of list entry idx
  function automatic logic [2:0] seq_chan(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd0, 3'd1: return {1'b0, idx};
      3'd3:       return 3'd1;
      3'd4:       return {1'b0, idx} + 3'd2;
      3'd5:       return {1'b0, idx} + 3'd4;
      3'd6:       return 3'd6;
      default:    return 3'd0;
    endcase
  endfunction

  // settling interval in microseconds
  function automatic int unsigned ival_us(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 5;
      3'd2:    return 10;
      3'd3:    return 20;
      3'd4:    return 50;
      3'd5:    return 100;
      3'd6:    return 200;
      default: return 500;
    endcase
  endfunction

endpackage

// File: rtl/seq_down_timer.sv
module seq_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/seq_median_filter.sv
module seq_median_filter #(
  parameter int DW = 12,
  parameter int N  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic          first,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] result
);
  // N - 2 must be a power of two so that the mean is a shift
  localparam int SW = DW + $clog2(N + 1);
  localparam int SH = $clog2(N - 2);

  logic [SW-1:0] sum_q, sum_n;
  logic [DW-1:0] mn_q, mn_n, mx_q, mx_n;

  function automatic logic [DW-1:0] trim_mean(input logic [SW-1:0] s,
                                               input logic [DW-1:0] lo,
                                               input logic [DW-1:0] hi);
    logic [SW-1:0] t;
    t = s - SW'(lo) - SW'(hi);
    return DW'(t >> SH);
  endfunction

  always_comb begin
    sum_n  = first ? SW'(din) : sum_q + SW'(din);
    mn_n   = (first || din < mn_q) ? din : mn_q;
    mx_n   = (first || din > mx_q) ? din : mx_q;
    result = trim_mean(sum_n, mn_n, mx_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      mn_q  <= '0;
      mx_q  <= '0;
    end else if (smp) begin
      sum_q <= sum_n;
      mn_q  <= mn_n;
      mx_q  <= mx_n;
    end
  end
endmodule

// File: rtl/seq_result_store.sv
module seq_result_store #(
  parameter int DW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_rst,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          has_data
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] cnt, ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ptr     <= '0;
      rd_data <= '0;
    end else if (clr) begin
      cnt <= '0;
      ptr <= '0;
    end else begin
      if (wr && cnt < PW'(DEPTH)) begin
        mem[cnt[IW-1:0]] <= wdata;
        cnt              <= cnt + PW'(1);
      end
      if (rd_rst) begin
        ptr <= '0;
      end else if (pop) begin
        if (ptr < cnt) begin
          rd_data <= mem[ptr[IW-1:0]];
          ptr     <= ptr + PW'(1);
          if (ptr == cnt - PW'(1)) cnt <= '0;
        end else begin
          rd_data <= '0;
        end
      end
    end
  end

  assign has_data = (cnt != '0);
endmodule

// File: rtl/tsc_seq_ctrl.sv
module tsc_seq_ctrl
  import tsc_seq_pkg::*;
#(
  parameter int DW         = 12,
  parameter int N_CONV     = 6,
  parameter int STEP_CYC   = 20,
  parameter int CLK_PER_US = 4,
  parameter int DEPTH      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [2:0]    seq_mode,
  input  logic [2:0]    ival_code,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] adc_data,
  output logic          adc_trk,
  output logic          adc_smp,
  output logic [2:0]    adc_chan,
  output logic          drv_en,
  output logic          osc_en,
  input  logic          pen_touch,
  output logic          pen_irq_n,
  output logic [1:0]    status
);
  localparam int TW       = $clog2(500 * CLK_PER_US + 1);
  localparam int HOLD_CYC = (28 * CLK_PER_US + 9) / 10;
  localparam int SCW      = $clog2(STEP_CYC);
  localparam int CW       = $clog2(N_CONV);

  function automatic logic [TW-1:0] wait_cycles(input logic [2:0] code);
    return TW'(ival_us(code) * CLK_PER_US);
  endfunction

  seq_state_e     state;
  logic [2:0]     mode_q, ival_q;
  logic [1:0]     axis;
  logic [CW-1:0]  conv_idx;
  logic [SCW-1:0] step;

  // named events
  logic [2:0]    len_start, len_run;
  logic [TW-1:0] wait_start, wait_run;
  logic start_acc, read_cmd, smp_ev, axis_done, last_axis, scan_end;
  logic tmr_load, tmr_busy, hold_nz;
  logic [TW-1:0] tmr_val;
  logic [DW-1:0] filt_res;
  logic store_has;

  assign len_start  = seq_len(seq_mode);
  assign len_run    = seq_len(mode_q);
  assign wait_start = wait_cycles(ival_code);
  assign wait_run   = wait_cycles(ival_q);

  assign start_acc = cmd_valid && cmd_byte == CMD_START && state == ST_IDLE;
  assign read_cmd  = cmd_valid && cmd_byte == CMD_READ;
  assign smp_ev    = state == ST_CONV && step == SCW'(STEP_CYC - 1);
  assign axis_done = smp_ev && conv_idx == CW'(N_CONV - 1);
  assign last_axis = ({1'b0, axis} + 3'd1) == len_run;
  assign scan_end  = axis_done && last_axis;

  assign tmr_load = (start_acc && len_start != 3'd0 && wait_start != '0) ||
                    (axis_done && !last_axis && wait_run != '0);
  assign tmr_val  = start_acc ? wait_start - TW'(1) : wait_run - TW'(1);

  seq_down_timer #(.W(TW)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .busy(tmr_busy)
  );

  seq_down_timer #(.W(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(scan_end), .val(TW'(HOLD_CYC)), .busy(hold_nz)
  );

  seq_median_filter #(.DW(DW), .N(N_CONV)) u_filt (
    .clk(clk), .rst_n(rst_n), .smp(smp_ev), .first(conv_idx == '0),
    .din(adc_data), .result(filt_res)
  );

  seq_result_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .wr(axis_done), .wdata(filt_res),
    .rd_rst(read_cmd), .pop(rd_pop), .rd_data(rd_data), .has_data(store_has)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= '0;
      ival_q   <= '0;
      axis     <= '0;
      conv_idx <= '0;
      step     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_acc) begin
          mode_q   <= seq_mode;
          ival_q   <= ival_code;
          axis     <= '0;
          conv_idx <= '0;
          step     <= '0;
          if (len_start != 3'd0)
            state <= (wait_start == '0) ? ST_CONV : ST_WAIT;
        end
        ST_WAIT: if (!tmr_busy) begin
          state <= ST_CONV;
          step  <= '0;
        end
        ST_CONV: if (smp_ev) begin
          step <= '0;
          if (axis_done) begin
            conv_idx <= '0;
            if (last_axis) begin
              state <= ST_IDLE;
            end else begin
              axis  <= axis + 2'd1;
              state <= (wait_run == '0) ? ST_CONV : ST_WAIT;
            end
          end else begin
            conv_idx <= conv_idx + CW'(1);
          end
        end else begin
          step <= step + SCW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_WAIT: status = 2'b01;
      ST_CONV: status = 2'b10;
      default: status = store_has ? 2'b11 : 2'b00;
    endcase
  end

  assign adc_trk   = state == ST_CONV;
  assign adc_smp   = smp_ev;
  assign adc_chan  = seq_chan(mode_q, axis);
  assign drv_en    = state != ST_IDLE && adc_chan < 3'd4;
  assign osc_en    = state != ST_IDLE || hold_nz;
  assign pen_irq_n = (state != ST_IDLE) ? 1'b0 : (hold_nz ? 1'b1 : !pen_touch);

endmodule

// File: rtl/seq_ctrl_checker.sv
module seq_ctrl_checker #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic [2:0]    seq_mode,
  input logic          rd_pop,
  input logic [DW-1:0] rd_data,
  input logic          adc_trk,
  input logic          adc_smp,
  input logic          osc_en,
  input logic          pen_irq_n,
  input logic [1:0]    status,
  input logic          scan_end
);
  logic busy;
  assign busy = (status == 2'b01) || (status == 2'b10);

  p_smp_in_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_smp |-> adc_trk && status == 2'b10);

  p_wait_no_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b01 |-> !adc_trk);

  p_busy_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pen_irq_n && osc_en);

  p_hold_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |=> osc_en && pen_irq_n);

  p_reserved_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte == 8'hAE && !busy && seq_mode == 3'b111 |=> status == 2'b00);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !scan_end && cmd_valid && cmd_byte == 8'hAE |=> (status == 2'b01 || status == 2'b10));

  p_empty_pop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b00 && rd_pop |=> rd_data == '0);
endmodule

bind tsc_seq_ctrl seq_ctrl_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .seq_mode(seq_mode), .rd_pop(rd_pop), .rd_data(rd_data), .adc_trk(adc_trk),
  .adc_smp(adc_smp), .osc_en(osc_en), .pen_irq_n(pen_irq_n), .status(status),
  .scan_end(scan_end)
);

// File: tb/tb_tsc_seq_ctrl.sv
module tb_tsc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 4;
  localparam int N    = 6;
  localparam int STEP = 20;
  localparam int HOLD = 12;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rd_pop = 0, pen_touch = 0;
  logic [7:0] cmd_byte = 0;
  logic [2:0] seq_mode = 0, ival_code = 0;
  logic [11:0] rd_data, adc_data;
  logic adc_trk, adc_smp, drv_en, osc_en, pen_irq_n;
  logic [2:0] adc_chan;
  logic [1:0] status;

  int checks = 0, errors = 0;
  int gsmp = 0, wait_n = 0, conv_n = 0, badpen = 0;
  bit force_full = 0, pop_d = 0, finished = 0;
  logic [11:0] exp_q[$];
  logic [2:0]  ch_q[$];

  tsc_seq_ctrl #(.CLK_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .seq_mode(seq_mode), .ival_code(ival_code), .rd_pop(rd_pop), .rd_data(rd_data),
    .adc_data(adc_data), .adc_trk(adc_trk), .adc_smp(adc_smp), .adc_chan(adc_chan),
    .drv_en(drv_en), .osc_en(osc_en), .pen_touch(pen_touch), .pen_irq_n(pen_irq_n),
    .status(status)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [11:0] sample_val(input int g);
    if (force_full) return 12'hFFF;
    return 12'((g * 263 + g * g * 17 + 91) % 4096);
  endfunction

  assign adc_data = sample_val(gsmp);

  function automatic int ref_len(input logic [2:0] m);
    int t[8] = '{4, 2, 1, 1, 2, 2, 1, 0};
    return t[m];
  endfunction

  function automatic logic [2:0] ref_chan(input logic [2:0] m, input int i);
    case (m)
      3'd0: return 3'(i);
      3'd1: return 3'(i);
      3'd2: return 3'd0;
      3'd3: return 3'd1;
      3'd4: return 3'(2 + i);
      3'd5: return 3'(4 + i);
      default: return 3'd6;
    endcase
  endfunction

  function automatic int ref_us(input logic [2:0] c);
    int t[8] = '{0, 5, 10, 20, 50, 100, 200, 500};
    return t[c];
  endfunction

  function automatic logic [11:0] exp_axis(input int base);
    int s = 0, mn = 4095, mx = 0;
    for (int k = 0; k < N; k++) begin
      int v = int'(sample_val(base + k));
      s += v;
      if (v < mn) mn = v;
      if (v > mx) mx = v;
    end
    return 12'((s - mn - mx) / (N - 2));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // ADC model and channel recorder
  always @(posedge clk) if (rst_n && adc_smp) begin
    gsmp <= gsmp + 1;
    ch_q.push_back(adc_chan);
  end

  always @(negedge clk) if (rst_n) begin
    if (status == 2'b01) wait_n++;
    if (status == 2'b10) conv_n++;
    if ((status == 2'b01 || status == 2'b10) && (pen_irq_n || !osc_en)) badpen++;
  end

  // scoreboard monitor
  always @(posedge clk) pop_d <= rd_pop;
  always @(negedge clk) if (pop_d) begin
    logic [11:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 12'd0;
    check(rd_data == e, "R4/R7 readout", rd_data, e);
  end

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1; cmd_byte = b;
    @(negedge clk); cmd_valid = 0; cmd_byte = 0;
  endtask

  task automatic read_out(input bit rewind, input int k);
    if (rewind) send_cmd(8'hAF);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); rd_pop = 1;
      @(negedge clk); rd_pop = 0;
    end
    @(negedge clk);
  endtask

  task automatic run_scan(input logic [2:0] m, input logic [2:0] iv, input bit poke);
    int len = ref_len(m);
    int n = 0;
    @(negedge clk);
    seq_mode = m; ival_code = iv;
    exp_q.delete(); ch_q.delete();
    wait_n = 0; conv_n = 0; badpen = 0;
    for (int a = 0; a < len; a++) exp_q.push_back(exp_axis(gsmp + a * N));
    send_cmd(8'hAE);
    if (poke) begin
      repeat (3) @(negedge clk);
      seq_mode = 3'd0;
      send_cmd(8'hAE);
      check(status == 2'b01 || status == 2'b10, "R8 still busy after start", status, 2);
    end
    while (status == 2'b01 || status == 2'b10) @(negedge clk);
    check(wait_n == len * ref_us(iv) * CPU, "R2 wait cycles", wait_n, len * ref_us(iv) * CPU);
    check(conv_n == len * N * STEP, "R3 conversion cycles", conv_n, len * N * STEP);
    check(ch_q.size() == len * N, "R3 R8 sample count", ch_q.size(), len * N);
    for (int i = 0; i < ch_q.size(); i++)
      if (ch_q[i] != ref_chan(m, i / N))
        check(0, "R1 channel order", ch_q[i], ref_chan(m, i / N));
    check(ch_q.size() == len * N, "R1 channel list length", ch_q.size(), len * N);
    check(badpen == 0, "R6 R10 pen low and oscillator on while busy", badpen, 0);
    if (len != 0) begin
      check(status == 2'b11, "R5 data available", status, 3);
      if (pen_touch) begin
        while (pen_irq_n && n < 100) begin n++; @(negedge clk); end
        check(n == HOLD, "R6 hold window", n, HOLD);
        check(!osc_en, "R10 oscillator off after hold", osc_en, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status == 2'b00, "R5 reset status", status, 0);
    check(pen_irq_n == 1'b1, "R6 reset pen output", pen_irq_n, 1);
    check(!osc_en && !adc_trk, "R10 reset enables", osc_en, 0);
    check(rd_data == 12'd0, "R7 reset data", rd_data, 0);

    pen_touch = 1;
    run_scan(3'd0, 3'd0, 0);             // full scan, no settling
    read_out(1, 6);                       // four results then two zero pads
    check(status == 2'b00, "R7 store emptied after full read", status, 0);

    run_scan(3'd1, 3'd1, 0);             // X,Y with 5 us
    read_out(1, 1);
    check(status == 2'b11, "R7 partial read keeps data", status, 3);
    read_out(0, 2);
    check(status == 2'b00, "R7 emptied after last", status, 0);

    run_scan(3'd5, 3'd3, 0);             // temperatures, 20 us
    read_out(1, 2);
    run_scan(3'd6, 3'd7, 0);             // auxiliary, 500 us
    read_out(1, 2);
    run_scan(3'd2, 3'd2, 1);             // X only, start poked mid-run
    read_out(1, 2);

    force_full = 1;
    run_scan(3'd3, 3'd4, 0);             // all samples full scale
    read_out(1, 1);
    force_full = 0;

    run_scan(3'd4, 3'd5, 0);             // Z1,Z2 with 100 us, left unread
    pen_touch = 0;
    @(negedge clk); seq_mode = 3'd7;
    send_cmd(8'hAE);
    check(status == 2'b00, "R9 reserved mode idle and empty", status, 0);
    check(!osc_en && pen_irq_n, "R9 reserved mode no busy flag", pen_irq_n, 1);
    exp_q.delete();
    read_out(1, 2);                       // zeros expected

    run_scan(3'd6, 3'd6, 0);
    read_out(1, 3);
    check(status == 2'b00, "R5 idle empty", status, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule